// File: doc/BRIEF.md
# Serial Port Interrupt Event Selector

This block turns the status strobes of one direction of a multichannel, frame-synchronized serial port into the single interrupt line that the CPU sees. The serial engine reports four kinds of events as one-cycle strobes: a finished word, a detected frame sync, an unexpected frame sync, and an overwrite of the receive shift buffer while the receive data is still unread. A two-bit mode input chooses the cause that fires the CPU interrupt. The choices are every word, every block of sixteen channel words, every frame sync, or only frame-sync errors.

The block finds block boundaries itself by counting finished words, and each frame sync restarts that count. A DMA request output runs alongside the CPU interrupt and always follows finished words, whatever the mode. The block also holds two sticky flags, sync error and receive full, and sends the serial engine a one-cycle strobe telling it to abort and restart the current word after an unexpected frame sync. Software clears the flags through write-one-to-clear strobes. Reading the receive data also clears the full flag.

Top module: `sp_irq_select`

## Requirements
- R1: While rstN is low, and on the first clock after it is released, cpuIrq, dmaReq, abortRestart, syncErrFlag and fullFlag are all 0.
- R2: With modeSel = 2'b00, a wordDone strobe produces a one-cycle cpuIrq pulse on the following clock.
- R3: With modeSel = 2'b01, cpuIrq pulses on the clock after the 16th wordDone counted since the last frame sync or the last block end.
- R4: With modeSel = 2'b10, every frameSync strobe produces a cpuIrq pulse on the following clock.
- R5: With modeSel = 2'b11, a syncErr strobe produces a cpuIrq pulse on the following clock.
- R6: Events that the current mode does not select never produce cpuIrq.
- R7: dmaReq is high exactly on the clock after each wordDone, independent of modeSel.
- R8: abortRestart is high exactly on the clock after each syncErr.
- R9: syncErrFlag is set by syncErr and stays set until clrSyncErr is applied without syncErr. A set and a clear in the same cycle leave the flag set.
- R10: fullFlag is set by overwrite. It is cleared by clrFull or by dataRead in a cycle without overwrite. An overwrite in the same cycle as a clear wins.
- R11: A frameSync restarts the word count. A wordDone in the same cycle as the frameSync counts as the first word of the new block.
- R12: A modeSel change applies to the events of the cycle in which the new value is present, and a mode change on its own produces no cpuIrq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Interrupt cause: 00 word, 01 block end, 10 frame sync, 11 sync error |
| wordDone | input | 1 | Strobe: one channel word finished |
| frameSync | input | 1 | Strobe: frame sync detected |
| syncErr | input | 1 | Strobe: unexpected frame sync during a word |
| overwrite | input | 1 | Strobe: receive shift buffer overwritten while data unread |
| dataRead | input | 1 | Strobe: receive data register read |
| clrSyncErr | input | 1 | Write-one-to-clear for the sync-error flag |
| clrFull | input | 1 | Write-one-to-clear for the full flag |
| cpuIrq | output | 1 | One-cycle CPU interrupt pulse |
| dmaReq | output | 1 | One-cycle DMA request pulse per word |
| abortRestart | output | 1 | One-cycle strobe telling the engine to abort and restart the word |
| syncErrFlag | output | 1 | Sticky unexpected-frame-sync flag |
| fullFlag | output | 1 | Sticky receive overrun flag |

## Verification
The assertions assume that every input is a clean, single-cycle-capable strobe sampled at the rising edge, and that modeSel is free to change on any cycle. They make no assumption that events are mutually exclusive. The stimulus is driven on the falling edge. It mixes random strobes in every mode with deliberate collisions: a frame sync and a word in the same cycle, a set and a clear in the same cycle, and a mode change every cycle. Together these cover the orderings that the flag and counter rules depend on.

// File: rtl/sp_irq_pkg.sv
package sp_irq_pkg;

  typedef enum logic [1:0] {
    MODE_WORD    = 2'b00,
    MODE_BLOCK   = 2'b01,
    MODE_FRAME   = 2'b10,
    MODE_SYNCERR = 2'b11
  } irqMode_e;

  localparam int NUM_CAUSES = 4;

  typedef struct packed {
    logic fireIrq;
    logic fireDma;
    logic fireAbort;
    logic setSync;
    logic clrSync;
    logic setFull;
    logic clrFull;
  } ctrlStrobes_t;

endpackage

// File: rtl/sp_irq_ctrl.sv
module sp_irq_ctrl
  import sp_irq_pkg::*;
#(
  parameter int BLOCK_WORDS = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   modeSel,
  input  logic         wordDone,
  input  logic         frameSync,
  input  logic         syncErr,
  input  logic         overwrite,
  input  logic         dataRead,
  input  logic         clrSyncErr,
  input  logic         clrFull,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;

  logic blockEvt;
  logic [NUM_CAUSES-1:0] causeVec;

  generate
    if (BLOCK_WORDS > 1) begin : g_counted
      localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_WORDS - 1);
      logic [CNT_W-1:0] wordCnt;

      assign blockEvt = wordDone && !frameSync && (wordCnt == LAST);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wordCnt <= '0;
        end else if (frameSync) begin
          wordCnt <= wordDone ? CNT_W'(1) : '0;
        end else if (wordDone) begin
          wordCnt <= (wordCnt == LAST) ? '0 : wordCnt + 1'b1;
        end
      end
    end else begin : g_single
      assign blockEvt = wordDone;
    end
  endgenerate

  // order follows the mode encoding: index = modeSel
  assign causeVec = {syncErr, frameSync, blockEvt, wordDone};

  always_comb begin
    strobes           = '0;
    strobes.fireIrq   = causeVec[modeSel];
    strobes.fireDma   = wordDone;
    strobes.fireAbort = syncErr;
    strobes.setSync   = syncErr;
    strobes.clrSync   = clrSyncErr;
    strobes.setFull   = overwrite;
    strobes.clrFull   = clrFull || dataRead;
  end

endmodule

// File: rtl/sp_irq_dp.sv
module sp_irq_dp
  import sp_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output logic         cpuIrq,
  output logic         dmaReq,
  output logic         abortRestart,
  output logic         syncErrFlag,
  output logic         fullFlag
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuIrq       <= 1'b0;
      dmaReq       <= 1'b0;
      abortRestart <= 1'b0;
    end else begin
      cpuIrq       <= strobes.fireIrq;
      dmaReq       <= strobes.fireDma;
      abortRestart <= strobes.fireAbort;
    end
  end

  // sticky flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncErrFlag <= 1'b0;
      fullFlag    <= 1'b0;
    end else begin
      if (strobes.setSync)      syncErrFlag <= 1'b1;
      else if (strobes.clrSync) syncErrFlag <= 1'b0;
      if (strobes.setFull)      fullFlag <= 1'b1;
      else if (strobes.clrFull) fullFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/sp_irq_select.sv
module sp_irq_select
  import sp_irq_pkg::*;
#(
  parameter int BLOCK_WORDS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       wordDone,
  input  logic       frameSync,
  input  logic       syncErr,
  input  logic       overwrite,
  input  logic       dataRead,
  input  logic       clrSyncErr,
  input  logic       clrFull,
  output logic       cpuIrq,
  output logic       dmaReq,
  output logic       abortRestart,
  output logic       syncErrFlag,
  output logic       fullFlag
);

  ctrlStrobes_t strobes;

  sp_irq_ctrl #(.BLOCK_WORDS(BLOCK_WORDS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .wordDone   (wordDone),
    .frameSync  (frameSync),
    .syncErr    (syncErr),
    .overwrite  (overwrite),
    .dataRead   (dataRead),
    .clrSyncErr (clrSyncErr),
    .clrFull    (clrFull),
    .strobes    (strobes)
  );

  sp_irq_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .cpuIrq       (cpuIrq),
    .dmaReq       (dmaReq),
    .abortRestart (abortRestart),
    .syncErrFlag  (syncErrFlag),
    .fullFlag     (fullFlag)
  );

endmodule

// File: rtl/sp_irq_select_chk.sv
module sp_irq_select_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       wordDone,
  input logic       frameSync,
  input logic       syncErr,
  input logic       overwrite,
  input logic       dataRead,
  input logic       clrSyncErr,
  input logic       clrFull,
  input logic       cpuIrq,
  input logic       dmaReq,
  input logic       abortRestart,
  input logic       syncErrFlag,
  input logic       fullFlag
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !(cpuIrq || dmaReq || abortRestart || syncErrFlag || fullFlag));

  a_r2_word_irq: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && wordDone) |=> cpuIrq);

  a_r3_block_needs_word: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01 && !wordDone) |=> !cpuIrq);

  a_r4_frame_irq: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10 && frameSync) |=> cpuIrq);

  a_r5_err_irq: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11 && syncErr) |=> cpuIrq);

  a_r6_no_unselected: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> (($past(modeSel) == 2'b00 && $past(wordDone)) ||
                ($past(modeSel) == 2'b01 && $past(wordDone)) ||
                ($past(modeSel) == 2'b10 && $past(frameSync)) ||
                ($past(modeSel) == 2'b11 && $past(syncErr))));

  a_r7_dma_follows: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |=> dmaReq);

  a_r7_dma_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wordDone |=> !dmaReq);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |=> abortRestart);

  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !syncErr |=> !abortRestart);

  a_r9_sync_set: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |=> syncErrFlag);

  a_r9_sync_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrSyncErr && !syncErr) |=> !syncErrFlag);

  a_r9_sync_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!clrSyncErr && !syncErr) |=> $stable(syncErrFlag));

  a_r10_full_set: assert property (@(posedge clk) disable iff (!rstN)
    overwrite |=> fullFlag);

  a_r10_full_clear: assert property (@(posedge clk) disable iff (!rstN)
    ((clrFull || dataRead) && !overwrite) |=> !fullFlag);

  a_r10_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!clrFull && !dataRead && !overwrite) |=> $stable(fullFlag));

  a_r12_no_mode_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (!wordDone && !frameSync && !syncErr) |=> !cpuIrq);

endmodule

bind sp_irq_select sp_irq_select_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .modeSel      (modeSel),
  .wordDone     (wordDone),
  .frameSync    (frameSync),
  .syncErr      (syncErr),
  .overwrite    (overwrite),
  .dataRead     (dataRead),
  .clrSyncErr   (clrSyncErr),
  .clrFull      (clrFull),
  .cpuIrq       (cpuIrq),
  .dmaReq       (dmaReq),
  .abortRestart (abortRestart),
  .syncErrFlag  (syncErrFlag),
  .fullFlag     (fullFlag)
);

// File: tb/sim_sp_irq_select.sv
`timescale 1ns/1ps
module sim_sp_irq_select;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       wordDone = 1'b0, frameSync = 1'b0, syncErr = 1'b0;
  logic       overwrite = 1'b0, dataRead = 1'b0, clrSyncErr = 1'b0, clrFull = 1'b0;
  logic       cpuIrq, dmaReq, abortRestart, syncErrFlag, fullFlag;

  always #4 clk = ~clk;

  sp_irq_select u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .wordDone(wordDone),
    .frameSync(frameSync), .syncErr(syncErr), .overwrite(overwrite),
    .dataRead(dataRead), .clrSyncErr(clrSyncErr), .clrFull(clrFull),
    .cpuIrq(cpuIrq), .dmaReq(dmaReq), .abortRestart(abortRestart),
    .syncErrFlag(syncErrFlag), .fullFlag(fullFlag)
  );

  int nChecks = 0;
  int nFail   = 0;

  // reference model state
  int    mCnt = 0;
  bit    eIrq = 0, eDma = 0, eAbort = 0, eSync = 0, eFull = 0;
  bit    primed = 0;
  string irqTag = "R1";
  string otherTag = "R1";
  string forceTag = "";

  task automatic chk(input logic act, input bit exp, input string tag, input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk(cpuIrq, eIrq, irqTag, "cpuIrq");
    chk(dmaReq, eDma, (otherTag == "R1") ? "R1" : "R7", "dmaReq");
    chk(abortRestart, eAbort, (otherTag == "R1") ? "R1" : "R8", "abortRestart");
    chk(syncErrFlag, eSync, (otherTag == "R1") ? "R1" : "R9", "syncErrFlag");
    chk(fullFlag, eFull, (otherTag == "R1") ? "R1" : "R10", "fullFlag");
  endtask

  // one cycle: compare, apply inputs, advance the model
  task automatic step(input bit rst, input bit [1:0] m, input bit wd, input bit fs,
                      input bit se, input bit ow, input bit rd, input bit cs, input bit cf);
    bit blk, sel;
    @(negedge clk);
    if (primed) compareAll();
    primed = 1;
    rstN = !rst; modeSel = m; wordDone = wd; frameSync = fs; syncErr = se;
    overwrite = ow; dataRead = rd; clrSyncErr = cs; clrFull = cf;
    if (rst) begin
      mCnt = 0; eIrq = 0; eDma = 0; eAbort = 0; eSync = 0; eFull = 0;
      irqTag = "R1"; otherTag = "R1";
    end else begin
      blk = wd && !fs && (mCnt == 15);
      case (m)
        2'd0: sel = wd;
        2'd1: sel = blk;
        2'd2: sel = fs;
        default: sel = se;
      endcase
      eIrq = sel; eDma = wd; eAbort = se;
      if (se) eSync = 1; else if (cs) eSync = 0;
      if (ow) eFull = 1; else if (cf || rd) eFull = 0;
      if (fs) mCnt = wd ? 1 : 0;
      else if (wd) mCnt = blk ? 0 : mCnt + 1;
      otherTag = "ok";
      if (forceTag != "") irqTag = forceTag;
      else if (!sel) irqTag = "R6";
      else case (m)
        2'd0: irqTag = "R2";
        2'd1: irqTag = "R3";
        2'd2: irqTag = "R4";
        default: irqTag = "R5";
      endcase
    end
  endtask

  task automatic idle(input bit [1:0] m);
    step(0, m, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state, then the first cycle after release
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 1, 1, 0, 0, 0);
    idle(0);

    // R2: word mode with random words, frame syncs and errors ignored
    for (int i = 0; i < 40; i++)
      step(0, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, 0, 0, 0, 0);

    // R3: block mode, sync once then count through two blocks
    step(0, 1, 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 1, 1'($urandom_range(0, 3) != 0), 0, 0, 0, 0, 0, 0);

    // R11: frame sync mid block, with a word in the same cycle counting as first
    forceTag = "R11";
    step(0, 1, 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) step(0, 1, 1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) step(0, 1, 1, 0, 0, 0, 0, 0, 0);
    idle(1);
    forceTag = "";

    // R4: frame mode
    for (int i = 0; i < 30; i++)
      step(0, 2, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, 0, 0, 0, 0);

    // R5 and R8: error mode
    for (int i = 0; i < 30; i++)
      step(0, 3, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 2) == 0), 0, 0, 0, 0);

    // R6: error mode with only unselected events
    for (int i = 0; i < 10; i++) step(0, 3, 1, 1, 0, 0, 0, 0, 0);

    // R12: mode flips every cycle, with quiet cycles in between
    forceTag = "R12";
    for (int i = 0; i < 40; i++) begin
      step(0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, 0, 0, 0);
      idle(2'($urandom_range(0, 3)));
    end
    forceTag = "";

    // R9: set, hold, clear, and set colliding with clear
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    idle(0); idle(0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle(0);
    step(0, 0, 0, 0, 1, 0, 0, 1, 0);
    idle(0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle(0);

    // R10: overwrite, read clears, clear strobe, collisions
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle(0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);
    idle(0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 1);
    idle(0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 1);
    idle(0);

    // mixed random traffic in all modes
    for (int i = 0; i < 3000; i++)
      step(0, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 7) == 0),
           1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 5) == 0));

    // R1: reset in mid traffic
    step(1, 0, 1, 1, 1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(0);
    idle(0);

    summary();
    $finish;
  end

endmodule